// File: doc/BRIEF.md
# Host-Commanded Remote DMA Channel

This block moves data between a host-side data port and a local packet memory on command. Software loads a byte start address and a byte count through an 8-bit register port, picks byte or 16-bit word units and the host byte order, and then writes a 3-bit command. A remote-write command takes host words from the write stream and stores them at the current address. A remote-read command presents memory contents on the read stream. Each accepted unit advances the current address and lowers the remaining count.

When the count reaches zero the channel stops by itself and sets a completion flag, which can drive an interrupt. An abort command stops the channel at once. It leaves the address and count where they are, so software can see how far the transfer got. The send-packet command is decoded but only idles the channel, because the network side lies outside this block.

Both streams are valid/ready. The write stream's `wr_ready` is high only while a remote write is running with a non-zero count, and a beat moves when `wr_valid` and `wr_ready` are both high at a clock edge. The read stream's `rd_valid` is high only while a remote read is running, and `rd_data` is the memory content at the current address. The host may hold `rd_ready` low for as long as it likes; the address and count stay frozen until a beat is taken. The memory port is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle, and writes land on the clock edge where `mem_we` is high.

Top module: `remote_dma_ctrl`

## Requirements
- R1: After reset the channel is idle, `rd_valid`, `wr_ready` and `irq` are low, and the address, count, completion, interrupt-enable and config registers all read 0.
- R2: Offsets 1/2 hold the address low/high byte and offsets 3/4 hold the count low/high byte. Reads at these offsets return the live current address and remaining count. Writes to them are ignored while a transfer is active.
- R3: Offset 0 takes the command in bits [2:0]. 001 starts a remote read (`rd_valid` high), 010 starts a remote write (`wr_ready` high), 000 changes nothing, and 011 (send packet) idles the channel without moving data.
- R4: Any command with bit 2 set aborts, whatever the low bits are. The channel goes idle, the address keeps its advanced value, the count keeps its remaining value, and the completion flag is not raised.
- R5: During a remote write, each accepted beat is stored at the current address. The address then grows and the count shrinks by the number of bytes moved.
- R6: During a remote read, `rd_data` shows the memory content at the current address, and each accepted beat advances the address and count.
- R7: Config bit 0 (offset 7) selects word mode. In word mode a beat moves 2 bytes (address, address+1); in byte mode a beat moves 1 byte on `rd_data[7:0]`/`wr_data[7:0]`, and the upper read byte is 0.
- R8: Config bit 1 selects byte order in word mode. With 0, host bits [7:0] belong to the lower address. With 1, host bits [15:8] belong to the lower address.
- R9: In word mode, when the remaining count is 1, the beat moves only the byte at the current address. The next byte in memory is not written, and that byte's host position reads as 0.
- R10: When the count reaches 0 the channel goes idle and sets status bit 0 (offset 5). Later data-port accesses are ignored: memory and address stay unchanged, and `wr_ready`/`rd_valid` stay low.
- R11: Writing 1 to status bit 0 clears the completion flag; writing 0 leaves it set.
- R12: `irq` is high exactly when the completion flag is set and interrupt-enable bit 0 (offset 6) is 1.
- R13: A read or write command issued with a count of 0 moves no data and sets the completion flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rd_data | output | 8 | Register read data (combinational) |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Channel accepts a write beat |
| wr_data | input | 16 | Host write beat |
| rd_valid | output | 1 | Read beat available |
| rd_ready | input | 1 | Host takes the read beat |
| rd_data | output | 16 | Host read beat |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Byte enables: bit 0 = address, bit 1 = address+1 |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data, [7:0] at address |
| mem_rdata | input | 16 | Memory read data, [7:0] from address |
| irq | output | 1 | Completion interrupt |

## Verification
Random transfers use random start addresses, lengths from 1 to 24, both unit sizes and both byte orders. Each random write is read back over the same region, which separates lane-swap errors from step-size errors. Odd lengths in word mode test the single-byte last beat separately from full words. Directed sequences cover abort in the middle of a write, writes to the address register while busy, the no-op and send-packet codes, starting with a count of 0, and accesses after completion, each against a memory image the bench keeps itself.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_SEND,
    OP_ABORT
  } rdma_op_e;

  localparam logic [3:0] RA_CMD     = 4'd0;
  localparam logic [3:0] RA_ADDR_LO = 4'd1;
  localparam logic [3:0] RA_ADDR_HI = 4'd2;
  localparam logic [3:0] RA_CNT_LO  = 4'd3;
  localparam logic [3:0] RA_CNT_HI  = 4'd4;
  localparam logic [3:0] RA_STATUS  = 4'd5;
  localparam logic [3:0] RA_IRQEN   = 4'd6;
  localparam logic [3:0] RA_CFG     = 4'd7;
endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode
  import rdma_pkg::*;
(
  input  logic [2:0] cmd_bits,
  output rdma_op_e   op
);
  always_comb begin
    if (cmd_bits[2]) op = OP_ABORT;  // top bit has priority
    else begin
      unique case (cmd_bits[1:0])
        2'b01:   op = OP_READ;
        2'b10:   op = OP_WRITE;
        2'b11:   op = OP_SEND;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rdma_lane_map.sv
module rdma_lane_map #(
  parameter int LANES = 2
) (
  input  logic               cfg_word,
  input  logic               cfg_swap,
  input  logic               single,
  input  logic               mem_we,
  input  logic [8*LANES-1:0] host_wdata,
  input  logic [8*LANES-1:0] mem_rdata,
  output logic [8*LANES-1:0] mem_wdata,
  output logic [LANES-1:0]   mem_be,
  output logic [8*LANES-1:0] host_rdata
);
  logic [8*LANES-1:0] wr_swapped, rd_masked, rd_swapped;

  // Byte lane k of the memory pairs with host lane LANES-1-k when swapped.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wr_swapped[8*k +: 8] = host_wdata[8*(LANES-1-k) +: 8];
    assign rd_masked[8*k +: 8]  = (k == 0 || !single) ? mem_rdata[8*k +: 8] : 8'h00;
    assign rd_swapped[8*(LANES-1-k) +: 8] = rd_masked[8*k +: 8];
  end

  always_comb begin
    if (cfg_word) begin
      mem_wdata  = cfg_swap ? wr_swapped : host_wdata;
      mem_be     = single ? LANES'(1) : {LANES{1'b1}};
      host_rdata = cfg_swap ? rd_swapped : rd_masked;
    end else begin
      mem_wdata  = {{(8*LANES-8){1'b0}}, host_wdata[7:0]};
      mem_be     = LANES'(1);
      host_rdata = {{(8*LANES-8){1'b0}}, mem_rdata[7:0]};
    end
  end
endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_word,
  input  logic              addr_lo_we,
  input  logic              addr_hi_we,
  input  logic              cnt_lo_we,
  input  logic              cnt_hi_we,
  input  logic [7:0]        wdata,
  input  logic              cmd_we,
  input  rdma_op_e          op,
  input  logic              done_clr,
  input  logic              xfer,
  output logic              active,
  output logic              dir_wr,
  output logic              single,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  rem_cnt,
  output logic              done
);
  logic [CNT_W-1:0] step;

  assign single = cfg_word && (rem_cnt == CNT_W'(1));
  assign step   = (cfg_word && !single) ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      dir_wr   <= 1'b0;
      cur_addr <= '0;
      rem_cnt  <= '0;
      done     <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (xfer && active) begin
        cur_addr <= cur_addr + ADDR_W'(step);
        rem_cnt  <= rem_cnt - step;
        if (rem_cnt == step) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
      if (!active) begin
        if (addr_lo_we) cur_addr[7:0]        <= wdata;
        if (addr_hi_we) cur_addr[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
        if (cnt_lo_we)  rem_cnt[7:0]         <= wdata;
        if (cnt_hi_we)  rem_cnt[CNT_W-1:8]   <= wdata[CNT_W-9:0];
      end
      if (cmd_we) begin
        case (op)
          OP_READ, OP_WRITE: begin
            dir_wr <= (op == OP_WRITE);
            if (rem_cnt == '0) done <= 1'b1;
            else active <= 1'b1;
          end
          OP_SEND, OP_ABORT: active <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_ABORT) |=> !active); // R4
  AST_ABORT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_ABORT && !xfer) |=> (cur_addr == $past(cur_addr) && !$rose(done))); // R4
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xfer && rem_cnt == step && !cmd_we) |=> (done && !active)); // R10
  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rem_cnt != '0)); // R10
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (op == OP_READ || op == OP_WRITE) && rem_cnt == '0) |=> (done && !active)); // R13
endmodule

// File: rtl/remote_dma_ctrl.sv
module remote_dma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic [3:0]        reg_rd_addr,
  output logic [7:0]        reg_rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [15:0]       wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [15:0]       rd_data,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              irq
);
  localparam int LANES = 2;

  rdma_op_e          op;
  logic              active, dir_wr, single, done, xfer;
  logic              cfg_word, cfg_swap, irq_en;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  rem_cnt;

  function automatic logic hit(input logic [3:0] a);
    return reg_wr_en && (reg_wr_addr == a);
  endfunction

  rdma_cmd_decode u_dec (.cmd_bits(reg_wr_data[2:0]), .op(op));

  rdma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .addr_lo_we(hit(RA_ADDR_LO)), .addr_hi_we(hit(RA_ADDR_HI)),
    .cnt_lo_we(hit(RA_CNT_LO)), .cnt_hi_we(hit(RA_CNT_HI)),
    .wdata(reg_wr_data), .cmd_we(hit(RA_CMD)), .op(op),
    .done_clr(hit(RA_STATUS) && reg_wr_data[0]), .xfer(xfer),
    .active(active), .dir_wr(dir_wr), .single(single),
    .cur_addr(cur_addr), .rem_cnt(rem_cnt), .done(done)
  );

  rdma_lane_map #(.LANES(LANES)) u_lanes (
    .cfg_word(cfg_word), .cfg_swap(cfg_swap), .single(single), .mem_we(mem_we),
    .host_wdata(wr_data), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .host_rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_word <= 1'b0;
      cfg_swap <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (hit(RA_CFG)) begin
        cfg_word <= reg_wr_data[0];
        cfg_swap <= reg_wr_data[1];
      end
      if (hit(RA_IRQEN)) irq_en <= reg_wr_data[0];
    end
  end

  assign wr_ready = active && dir_wr;
  assign rd_valid = active && !dir_wr;
  assign xfer     = (wr_valid && wr_ready) || (rd_valid && rd_ready);
  assign mem_we   = wr_valid && wr_ready;
  assign mem_addr = cur_addr;
  assign irq      = done && irq_en;

  always_comb begin
    case (reg_rd_addr)
      RA_CMD:     reg_rd_data = {6'b0, dir_wr, active};
      RA_ADDR_LO: reg_rd_data = cur_addr[7:0];
      RA_ADDR_HI: reg_rd_data = 8'(cur_addr >> 8);
      RA_CNT_LO:  reg_rd_data = rem_cnt[7:0];
      RA_CNT_HI:  reg_rd_data = 8'(rem_cnt >> 8);
      RA_STATUS:  reg_rd_data = {7'b0, done};
      RA_IRQEN:   reg_rd_data = {7'b0, irq_en};
      RA_CFG:     reg_rd_data = {6'b0, cfg_swap, cfg_word};
      default:    reg_rd_data = 8'h00;
    endcase
  end

  AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready)); // R3
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R12
  AST_WRITE_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be[0]); // R7
  AST_LAST_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cfg_word && rem_cnt == CNT_W'(1)) |-> (mem_be == 2'b01)); // R9
endmodule

// File: tb/sim_remote_dma_ctrl.sv
module sim_remote_dma_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [3:0] reg_wr_addr = '0, reg_rd_addr = '0;
  logic [7:0] reg_wr_data = '0, reg_rd_data;
  logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic mem_we, irq;
  logic [1:0] mem_be;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0] mem [256];
  logic [7:0] ref_m [256];
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  remote_dma_ctrl u0 (.*);

  assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
  always @(posedge clk) if (mem_we) begin
    if (mem_be[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
    if (mem_be[1]) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    reg_rd_addr = a; #1; d = reg_rd_data;
  endtask

  task automatic host_write(input logic [15:0] d, output logic got);
    @(negedge clk); wr_valid = 1'b1; wr_data = d; got = wr_ready;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic host_read(output logic got, output logic [15:0] d);
    @(negedge clk); rd_ready = 1'b1; got = rd_valid; d = rd_data;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) n++;
    return n;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] a, input int n,
                                           input logic word, input logic swap);
    logic [7:0] l0, l1;
    l0 = ref_m[a];
    l1 = (n == 2) ? ref_m[8'(a + 8'd1)] : 8'h00;
    if (!word) return {8'h00, l0};
    return swap ? {l0, l1} : {l1, l0};
  endfunction

  task automatic setup(input logic [15:0] a, input logic [15:0] c,
                       input logic word, input logic swap, input logic [2:0] cmd);
    reg_wr(4'd5, 8'h01);
    reg_wr(4'd7, {6'b0, swap, word});
    reg_wr(4'd1, a[7:0]); reg_wr(4'd2, a[15:8]);
    reg_wr(4'd3, c[7:0]); reg_wr(4'd4, c[15:8]);
    reg_wr(4'd0, {5'b0, cmd});
  endtask

  task automatic run_write(input logic [7:0] a0, input int cnt, input logic word, input logic swap);
    logic [7:0] a = a0; int rem = cnt; logic got; logic [7:0] r;
    setup({8'h00, a0}, 16'(cnt), word, swap, 3'b010);
    while (rem > 0) begin
      int n = (word && rem >= 2) ? 2 : 1;
      logic [15:0] h = 16'($urandom);
      logic [7:0] lo_b = word && swap ? h[15:8] : h[7:0];
      ref_m[a] = lo_b;
      if (n == 2) ref_m[8'(a + 8'd1)] = swap ? h[7:0] : h[15:8];
      host_write(h, got);
      check("R5 write beat accepted", 32'(got), 32'd1);
      a = 8'(a + 8'(n)); rem -= n;
    end
    reg_rd(4'd5, r); check("R10 done after write", 32'(r), 32'd1);
    reg_rd(4'd1, r); check("R5 address advanced by count", 32'(r), 32'(8'(a0 + 8'(cnt))));
    reg_rd(4'd3, r); check("R5 count at zero", 32'(r), 32'd0);
    check("R7 R8 memory image after write", 32'(mem_mismatch()), 32'd0);
  endtask

  task automatic run_read(input logic [7:0] a0, input int cnt, input logic word, input logic swap);
    logic [7:0] a = a0; int rem = cnt; logic got; logic [15:0] d; logic [7:0] r;
    setup({8'h00, a0}, 16'(cnt), word, swap, 3'b001);
    while (rem > 0) begin
      int n = (word && rem >= 2) ? 2 : 1;
      logic [15:0] e = exp_read(a, n, word, swap);
      host_read(got, d);
      check("R6 read beat valid", 32'(got), 32'd1);
      check("R6 R8 read data", 32'(d), 32'(e));
      a = 8'(a + 8'(n)); rem -= n;
    end
    reg_rd(4'd5, r); check("R10 done after read", 32'(r), 32'd1);
    check("R10 rd_valid low after completion", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r; logic got; logic [15:0] d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); ref_m[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 wr_ready", 32'(wr_ready), 0);
    check("R1 irq", 32'(irq), 0);
    for (int k = 1; k < 8; k++) begin
      reg_rd(4'(k), r); check("R1 register zero", 32'(r), 0);
    end

    // R2 byte-wise programming and readback
    reg_wr(4'd1, 8'h34); reg_wr(4'd2, 8'h12); reg_wr(4'd3, 8'h56); reg_wr(4'd4, 8'h00);
    reg_rd(4'd1, r); check("R2 addr lo", 32'(r), 32'h34);
    reg_rd(4'd2, r); check("R2 addr hi", 32'(r), 32'h12);
    reg_rd(4'd3, r); check("R2 count lo", 32'(r), 32'h56);
    reg_rd(4'd4, r); check("R2 count hi", 32'(r), 32'h00);

    // R13 zero count start, R11 clear, R12 irq
    setup(16'h0020, 16'h0000, 1'b0, 1'b0, 3'b001);
    reg_rd(4'd5, r); check("R13 done on zero count", 32'(r), 1);
    check("R13 no read beat", 32'(rd_valid), 0);
    check("R12 irq masked", 32'(irq), 0);
    reg_wr(4'd6, 8'h01);
    check("R12 irq asserted", 32'(irq), 1);
    reg_wr(4'd5, 8'h00);
    reg_rd(4'd5, r); check("R11 write 0 keeps flag", 32'(r), 1);
    reg_wr(4'd5, 8'h01);
    reg_rd(4'd5, r); check("R11 write 1 clears flag", 32'(r), 0);
    check("R12 irq drops", 32'(irq), 0);

    // R3 command codes, R2 writes ignored while busy
    setup(16'h0010, 16'h0004, 1'b0, 1'b0, 3'b010);
    check("R3 write cmd opens write stream", 32'(wr_ready), 1);
    reg_wr(4'd1, 8'h99);
    reg_rd(4'd1, r); check("R2 addr write ignored while active", 32'(r), 32'h10);
    reg_wr(4'd0, 8'h00);
    check("R3 code 000 no effect", 32'(wr_ready), 1);
    reg_wr(4'd0, 8'h01);
    check("R3 read cmd opens read stream", 32'(rd_valid), 1);
    reg_wr(4'd0, 8'h03);
    check("R3 send code idles read", 32'(rd_valid), 0);
    check("R3 send code idles write", 32'(wr_ready), 0);
    reg_rd(4'd3, r); check("R3 send code keeps count", 32'(r), 4);

    // R4 abort mid-transfer
    setup(16'h0040, 16'h000A, 1'b0, 1'b0, 3'b010);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] h = 16'($urandom);
      ref_m[8'h40 + 8'(k)] = h[7:0];
      host_write(h, got);
    end
    reg_wr(4'd0, 8'h05);
    check("R4 abort stops stream", 32'(wr_ready), 0);
    reg_rd(4'd1, r); check("R4 address stays advanced", 32'(r), 32'h43);
    reg_rd(4'd3, r); check("R4 count keeps remainder", 32'(r), 7);
    reg_rd(4'd5, r); check("R4 no completion on abort", 32'(r), 0);
    host_write(16'hBEEF, got);
    check("R4 write after abort refused", 32'(got), 0);
    check("R4 memory after abort", 32'(mem_mismatch()), 0);

    // R9 odd length in word mode, both orders
    run_write(8'h80, 5, 1'b1, 1'b0);
    check("R9 byte past the end untouched", 32'(mem[8'h85]), 32'(ref_m[8'h85]));
    run_read(8'h80, 5, 1'b1, 1'b1);

    // R10 accesses after completion
    host_write(16'h1234, got);
    check("R10 write after done refused", 32'(got), 0);
    host_read(got, d);
    check("R10 read after done refused", 32'(got), 0);
    reg_rd(4'd1, r); check("R10 address unchanged after done", 32'(r), 32'h85);
    check("R10 memory unchanged after done", 32'(mem_mismatch()), 0);

    // Random transfers (R5 R6 R7 R8)
    for (int it = 0; it < 10; it++) begin
      logic [7:0] a = 8'($urandom_range(0, 8'hC0));
      int c = $urandom_range(1, 24);
      logic w = 1'($urandom);
      logic s = 1'($urandom);
      run_write(a, c, w, s);
      run_read(a, c, w, s);
      run_read(a, c, ~w, ~s);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule